// File: doc/BRIEF.md
# SerDes Test Pattern Engine

This block sits on the parallel side of a serial link and supports bit-error testing against external test equipment. A 3-bit mode input selects the pattern. The generator produces one 20-bit word per clock for the serializer. The checker takes 20-bit words from the deserializer and compares each one with a locally regenerated copy of the same pattern. Serial bit order is LSB first. Bit 0 of a word is therefore the earliest bit on the line.

For the pseudo-random modes, the checker has no fixed phase relation to the far-end source. It rebuilds its own shift register from the bits it receives. It declares lock after two consecutive words predicted without error. From then on it runs on its own state, and any mismatch sets a sticky fail flag. A 4-bit debug select can route that flag to an alarm output. A mode change restarts both the generator and the checker.

Top module: `serdes_ptn_engine`

## Requirements
- R1: After reset, txData is 0, locked, testFail and alarm are 0, and the stored user word is 0x66666.
- R2: Mode 000 and the reserved codes 110 and 111 behave as off: txData is 0, the checker never locks and testFail stays 0.
- R3: Mode 001 sends a toggling bit stream starting with 0, so every word is 0xAAAAA.
- R4: A change of modeSel is seen at the next clock edge. At that edge the generator loads an all-ones history and sends a zero word. Mode 010 then sends PRBS7, where each serial bit is the XOR of the bits 7 and 6 positions earlier, placed from bit 0 upward. The generator history is never all zero.
- R5: Mode 011 sends PRBS23 built the same way with taps 23 and 18.
- R6: Mode 100 sends PRBS31 built the same way with taps 31 and 28.
- R7: Mode 101 repeats the stored user word each clock. A pulse on userLoad stores userWordIn at the clock edge, and the new word appears on the next word.
- R8: In an active mode, the checker locks after 2 consecutive matching words. In toggle mode it locks 3 edges after the mode change. Mismatches seen before lock never set testFail.
- R9: Once locked, a mismatching received word sets testFail at the next edge. The flag stays high and the checker stays locked.
- R10: An errClear pulse clears testFail. A mode change clears both testFail and locked.
- R11: alarm equals testFail while debugSel is 0011, and is 0 for any other debugSel value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| modeSel | input | 3 | Pattern mode code |
| userLoad | input | 1 | Strobe that stores userWordIn |
| userWordIn | input | 20 | New user pattern word |
| errClear | input | 1 | Clears the sticky fail flag |
| debugSel | input | 4 | Debug route select, 0011 routes fail to alarm |
| rxData | input | 20 | Word from the deserializer |
| txData | output | 20 | Word to the serializer |
| locked | output | 1 | Checker is aligned to the received pattern |
| testFail | output | 1 | Sticky mismatch flag |
| alarm | output | 1 | Routed fail flag |

## Verification
Every mode code, including both reserved codes, is run with the generator looped back into the checker. Each generated word is compared with a bit-serial model of the selected polynomial. This separates the three tap pairs from each other, and it separates the toggle word and the user word (default and loaded) from the off state. Single-bit errors are injected while the checker is locked to show that the flag is sticky, that it clears, and that it follows the debug route. A constant bit error held during alignment shows that errors before lock are ignored and that lock is regained once the error is removed.

// File: rtl/ptn_pkg.sv
package ptn_pkg;
  localparam logic [2:0] MODE_OFF    = 3'b000;
  localparam logic [2:0] MODE_TOGGLE = 3'b001;
  localparam logic [2:0] MODE_PRBS7  = 3'b010;
  localparam logic [2:0] MODE_PRBS23 = 3'b011;
  localparam logic [2:0] MODE_PRBS31 = 3'b100;
  localparam logic [2:0] MODE_USER   = 3'b101;

  typedef enum logic [1:0] {
    KIND_OFF,
    KIND_TOGGLE,
    KIND_USER,
    KIND_PRBS
  } patKind_e;

  typedef struct packed {
    logic     restart;
    logic     seedChk;
    patKind_e kind;
    logic [4:0] tapLong;
    logic [4:0] tapShort;
  } ctrlStrobes_t;
endpackage

// File: rtl/ptn_ctrl.sv
module ptn_ctrl
  import ptn_pkg::*;
#(
  parameter int LOCK_WORDS = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [2:0]   modeSel,
  input  logic         errClear,
  input  logic         mismatch,
  output ctrlStrobes_t strobes,
  output logic         locked,
  output logic         testFail
);
  localparam int CNT_W = $clog2(LOCK_WORDS + 1);

  logic [2:0]       modeQ;
  logic [CNT_W-1:0] goodCnt;
  logic             lockedQ;
  logic             failQ;
  logic             restart;
  patKind_e         kind;

  assign restart = (modeSel != modeQ);

  always_comb begin
    kind              = KIND_OFF;
    strobes.tapLong   = 5'd7;
    strobes.tapShort  = 5'd6;
    case (modeSel)
      MODE_TOGGLE: kind = KIND_TOGGLE;
      MODE_USER:   kind = KIND_USER;
      MODE_PRBS7:  kind = KIND_PRBS;
      MODE_PRBS23: begin
        kind             = KIND_PRBS;
        strobes.tapLong  = 5'd23;
        strobes.tapShort = 5'd18;
      end
      MODE_PRBS31: begin
        kind             = KIND_PRBS;
        strobes.tapLong  = 5'd31;
        strobes.tapShort = 5'd28;
      end
      default: kind = KIND_OFF;
    endcase
    strobes.kind    = kind;
    strobes.restart = restart;
    strobes.seedChk = !lockedQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ   <= MODE_OFF;
      goodCnt <= '0;
      lockedQ <= 1'b0;
      failQ   <= 1'b0;
    end else begin
      modeQ <= modeSel;
      if (restart) begin
        goodCnt <= '0;
        lockedQ <= 1'b0;
        failQ   <= 1'b0;
      end else begin
        if (kind == KIND_OFF) begin
          goodCnt <= '0;
          lockedQ <= 1'b0;
        end else if (!lockedQ) begin
          if (mismatch) begin
            goodCnt <= '0;
          end else if (goodCnt == CNT_W'(LOCK_WORDS - 1)) begin
            goodCnt <= '0;
            lockedQ <= 1'b1;
          end else begin
            goodCnt <= goodCnt + 1'b1;
          end
        end
        if (errClear) begin
          failQ <= 1'b0;
        end else if (lockedQ && mismatch) begin
          failQ <= 1'b1;
        end
      end
    end
  end

  assign locked   = lockedQ;
  assign testFail = failQ;

  // R9
  fail_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (failQ && !errClear && !restart) |=> failQ);

  // R8
  no_fail_unlocked_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!lockedQ && !failQ) |=> !failQ);

  // R10
  restart_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    restart |=> (!failQ && !lockedQ));

  // R10
  clear_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    errClear |=> !failQ);

  // R2
  reserved_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 3'b110 || modeSel == 3'b111) |=> !lockedQ);
endmodule

// File: rtl/ptn_datapath.sv
module ptn_datapath
  import ptn_pkg::*;
#(
  parameter int              WORD_W     = 20,
  parameter int              HIST_W     = 31,
  parameter logic [WORD_W-1:0] USER_RESET = 20'h66666
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic              userLoad,
  input  logic [WORD_W-1:0] userWordIn,
  input  logic [WORD_W-1:0] rxData,
  output logic [WORD_W-1:0] txData,
  output logic              mismatch
);
  localparam int STEP_W = WORD_W + HIST_W;
  localparam int CAT_W  = 2 * WORD_W;

  function automatic logic [WORD_W-1:0] toggleWord();
    logic [WORD_W-1:0] w;
    for (int i = 0; i < WORD_W; i++) w[i] = (i % 2 == 1);
    return w;
  endfunction

  localparam logic [WORD_W-1:0] TOGGLE_WORD = toggleWord();

  // Advance the history by one word; bit 0 of the history is the newest bit.
  function automatic logic [STEP_W-1:0] lfsrAdvance(
    input logic [HIST_W-1:0] hist,
    input logic [4:0]        tl,
    input logic [4:0]        ts
  );
    logic [HIST_W-1:0] h;
    logic [WORD_W-1:0] o;
    logic              b;
    h = hist;
    for (int i = 0; i < WORD_W; i++) begin
      b    = h[tl - 5'd1] ^ h[ts - 5'd1];
      o[i] = b;
      h    = {h[HIST_W-2:0], b};
    end
    return {o, h};
  endfunction

  // Rebuild a history from the two most recent received words.
  function automatic logic [HIST_W-1:0] seedFrom(
    input logic [WORD_W-1:0] older,
    input logic [WORD_W-1:0] newer
  );
    logic [CAT_W-1:0]  cat;
    logic [HIST_W-1:0] s;
    cat = {newer, older};
    for (int j = 0; j < HIST_W; j++) s[j] = cat[CAT_W-1-j];
    return s;
  endfunction

  logic [HIST_W-1:0] genHist;
  logic [HIST_W-1:0] chkHist;
  logic [WORD_W-1:0] txQ;
  logic [WORD_W-1:0] userQ;
  logic [WORD_W-1:0] rxPrev;
  logic [STEP_W-1:0] genNext;
  logic [STEP_W-1:0] chkNext;
  logic [WORD_W-1:0] expected;

  assign genNext = lfsrAdvance(genHist, strobes.tapLong, strobes.tapShort);
  assign chkNext = lfsrAdvance(chkHist, strobes.tapLong, strobes.tapShort);

  always_comb begin
    case (strobes.kind)
      KIND_TOGGLE: expected = TOGGLE_WORD;
      KIND_USER:   expected = userQ;
      KIND_PRBS:   expected = chkNext[STEP_W-1:HIST_W];
      default:     expected = '0;
    endcase
  end

  assign mismatch = (expected != rxData);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      genHist <= '1;
      chkHist <= '1;
      txQ     <= '0;
      userQ   <= USER_RESET;
      rxPrev  <= '0;
    end else begin
      if (userLoad) userQ <= userWordIn;
      rxPrev <= rxData;
      if (strobes.restart) begin
        genHist <= '1;
        txQ     <= '0;
      end else begin
        case (strobes.kind)
          KIND_PRBS: begin
            txQ     <= genNext[STEP_W-1:HIST_W];
            genHist <= genNext[HIST_W-1:0];
          end
          KIND_TOGGLE: txQ <= TOGGLE_WORD;
          KIND_USER:   txQ <= userQ;
          default:     txQ <= '0;
        endcase
      end
      if (strobes.seedChk) chkHist <= seedFrom(rxPrev, rxData);
      else                 chkHist <= chkNext[HIST_W-1:0];
    end
  end

  assign txData = txQ;

  // R4
  gen_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.kind == KIND_PRBS) |-> (genHist != '0));

  // R4
  restart_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.restart |=> (txData == '0));
endmodule

// File: rtl/serdes_ptn_engine.sv
module serdes_ptn_engine
  import ptn_pkg::*;
#(
  parameter int         WORD_W     = 20,
  parameter int         HIST_W     = 31,
  parameter int         LOCK_WORDS = 2,
  parameter logic [3:0] ALARM_CODE = 4'b0011
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        modeSel,
  input  logic              userLoad,
  input  logic [WORD_W-1:0] userWordIn,
  input  logic              errClear,
  input  logic [3:0]        debugSel,
  input  logic [WORD_W-1:0] rxData,
  output logic [WORD_W-1:0] txData,
  output logic              locked,
  output logic              testFail,
  output logic              alarm
);
  ctrlStrobes_t strobes;
  logic         mismatch;

  ptn_ctrl #(.LOCK_WORDS(LOCK_WORDS)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .modeSel  (modeSel),
    .errClear (errClear),
    .mismatch (mismatch),
    .strobes  (strobes),
    .locked   (locked),
    .testFail (testFail)
  );

  ptn_datapath #(.WORD_W(WORD_W), .HIST_W(HIST_W)) u_data (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .userLoad   (userLoad),
    .userWordIn (userWordIn),
    .rxData     (rxData),
    .txData     (txData),
    .mismatch   (mismatch)
  );

  assign alarm = testFail && (debugSel == ALARM_CODE);

  // R11
  alarm_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    alarm |-> testFail);

  // R11
  alarm_gated_chk: assert property (@(posedge clk) disable iff (!rstN)
    (debugSel != ALARM_CODE) |-> !alarm);
endmodule

// File: tb/tb_serdes_ptn_engine.sv
module tb_serdes_ptn_engine;
  logic        clk = 1'b0;
  logic        rstN;
  logic [2:0]  modeSel;
  logic        userLoad;
  logic [19:0] userWordIn;
  logic        errClear;
  logic [3:0]  debugSel;
  logic [19:0] rxData;
  logic [19:0] txData;
  logic        locked;
  logic        testFail;
  logic        alarm;
  logic [19:0] errMask;

  int applied = 0;
  int miscomp = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  assign rxData = txData ^ errMask;

  serdes_ptn_engine dut (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .userLoad(userLoad),
    .userWordIn(userWordIn), .errClear(errClear), .debugSel(debugSel),
    .rxData(rxData), .txData(txData), .locked(locked),
    .testFail(testFail), .alarm(alarm)
  );

  // row = {mode, load, value}
  localparam logic [23:0] VEC [0:9] = '{
    {3'b001, 1'b0, 20'h00000},
    {3'b010, 1'b0, 20'h00000},
    {3'b011, 1'b0, 20'h00000},
    {3'b100, 1'b0, 20'h00000},
    {3'b101, 1'b0, 20'h00000},
    {3'b110, 1'b0, 20'h00000},
    {3'b101, 1'b1, 20'h12345},
    {3'b111, 1'b0, 20'h00000},
    {3'b000, 1'b0, 20'h00000},
    {3'b010, 1'b0, 20'h00000}
  };

  logic [30:0] mSr;
  logic [19:0] userModel;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    applied++;
    if (!ok) begin
      miscomp++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string reqOf(input logic [2:0] m);
    case (m)
      3'b001: return "R3";
      3'b010: return "R4";
      3'b011: return "R5";
      3'b100: return "R6";
      3'b101: return "R7";
      default: return "R2";
    endcase
  endfunction

  // Bit-serial reference: s[n] = s[n-a] ^ s[n-b], first bit into word bit 0.
  task automatic modelWord(input logic [2:0] m, output logic [19:0] w);
    int a, b;
    logic nb;
    a = (m == 3'b010) ? 7 : (m == 3'b011) ? 23 : 31;
    b = (m == 3'b010) ? 6 : (m == 3'b011) ? 18 : 28;
    for (int i = 0; i < 20; i++) begin
      nb   = mSr[a-1] ^ mSr[b-1];
      w[i] = nb;
      mSr  = {mSr[29:0], nb};
    end
  endtask

  task automatic setMode(input logic [2:0] m);
    @(negedge clk);
    modeSel = m;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miscomp++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscomp);
      $finish;
    end
  end

  initial begin
    logic [19:0] expW;
    rstN = 1'b0; modeSel = 3'b000; userLoad = 1'b0; userWordIn = '0;
    errClear = 1'b0; debugSel = 4'b0011; errMask = '0;
    userModel = 20'h66666;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check(txData == 0, "R1 tx", txData, 0);
    check(locked == 0, "R1 locked", locked, 0);
    check(testFail == 0, "R1 fail", testFail, 0);
    check(alarm == 0, "R1 alarm", alarm, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // vector table walk with loopback
    for (int v = 0; v < 10; v++) begin
      logic [2:0] m;
      bit active;
      m = VEC[v][23:21];
      active = (m >= 3'b001 && m <= 3'b101);
      @(negedge clk);
      modeSel = m;
      userLoad = VEC[v][20];
      userWordIn = VEC[v][19:0];
      if (VEC[v][20]) userModel = VEC[v][19:0];
      mSr = '1;
      @(negedge clk);
      userLoad = 1'b0;
      check(txData == 0, "R4 restart word", txData, 0);
      for (int w = 0; w < 10; w++) begin
        @(negedge clk);
        case (m)
          3'b001: expW = 20'hAAAAA;
          3'b010, 3'b011, 3'b100: modelWord(m, expW);
          3'b101: expW = userModel;
          default: expW = 20'h0;
        endcase
        check(txData == expW, reqOf(m), txData, expW);
      end
      check(locked == active, active ? "R8 lock" : "R2 no lock", locked, active);
      check(testFail == 0, "R9 no fail clean", testFail, 0);
      check(alarm == 0, "R11 alarm idle", alarm, 0);
    end

    // R8 lock timing in toggle mode
    @(negedge clk); modeSel = 3'b001;
    @(negedge clk);
    check(locked == 0, "R8 edge0", locked, 0);
    @(negedge clk);
    check(locked == 0, "R8 edge1", locked, 0);
    @(negedge clk);
    check(locked == 0, "R8 edge2", locked, 0);
    @(negedge clk);
    check(locked == 1, "R8 edge3", locked, 1);

    // R9 / R11 error injection in PRBS31
    setMode(3'b100);
    repeat (8) @(negedge clk);
    check(locked == 1, "R8 prbs31 lock", locked, 1);
    errMask = 20'h00010;
    @(negedge clk);
    errMask = '0;
    check(testFail == 1, "R9 set", testFail, 1);
    check(alarm == 1, "R11 routed", alarm, 1);
    repeat (3) @(negedge clk);
    check(testFail == 1, "R9 sticky", testFail, 1);
    check(locked == 1, "R9 stays locked", locked, 1);
    debugSel = 4'b0111;
    #1;
    check(alarm == 0, "R11 other code", alarm, 0);
    debugSel = 4'b0011;
    errClear = 1'b1;
    @(negedge clk);
    errClear = 1'b0;
    check(testFail == 0, "R10 clear", testFail, 0);
    repeat (3) @(negedge clk);
    check(testFail == 0, "R9 clean after clear", testFail, 0);

    // R10 mode change clears
    errMask = 20'h80000;
    @(negedge clk);
    errMask = '0;
    check(testFail == 1, "R9 set again", testFail, 1);
    setMode(3'b010);
    check(testFail == 0, "R10 mode change fail", testFail, 0);
    check(locked == 0, "R10 mode change lock", locked, 0);

    // R8 errors before lock are ignored
    @(negedge clk); modeSel = 3'b011; errMask = 20'h00001;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      check(testFail == 0, "R8 unlocked err", testFail, 0);
    end
    errMask = '0;
    repeat (8) @(negedge clk);
    check(locked == 1, "R8 relock", locked, 1);
    check(testFail == 0, "R8 no fail after relock", testFail, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscomp);
    $finish;
  end
endmodule